// File: doc/BRIEF.md
# Scan Bridge Address Selection Controller

This block sits behind a standard boundary-scan TAP on a shared backplane scan port. It decides whether the tester is talking to this device. Until the device is picked out, every instruction scan is taken as an address. Bits pass through the instruction register and fall off its low end, and the shared TDO line is never driven. When the TAP passes through Update-IR, the low seven bits of the instruction register are matched against three targets: the static slot address pins, one reserved broadcast address, and four multicast addresses, each of which is gated by a group register inside the device.

A slot match selects the device alone. It then drives TDO and takes instructions, including the one that opens its 3-bit group register for reading and writing. A broadcast match, or a match on an enabled multicast group, selects the device together with its peers. It then takes instructions but keeps TDO released, so that several devices never drive the line at once. A miss parks the device in an unselected state, where later address scans are compared again. Entering Test-Logic-Reset always returns the device to waiting for an address.

The scan port is paced by TCK alone. It has no valid/ready handshake, and there is no back-pressure: every TCK edge in a shift state moves exactly one bit.

Top module: `scan_addr_select`

## Requirements
- R1: While `trst_n` is low, `sel_state` reads 0 (waiting for an address), `tdo_oe` is low, and the group register is cleared to "no group".
- R2: The TAP follows the IEEE 1149.1 state graph. Five TCK edges with TMS high always reach Test-Logic-Reset, and being in Test-Logic-Reset forces `sel_state` to 0 on the next edge.
- R3: The instruction register is 8 bits wide. In Shift-IR each bit enters at the most significant end, so the first bit shifted lands in bit 0 after eight shifts. `tdo_oe` stays low during every shift while the device is not selected.
- R4: At Update-IR in state 0 or 1, if bits 6:0 of the instruction register equal `slot_addr`, `sel_state` becomes 2 (singly selected). Bit 7 is ignored for addressing.
- R5: At Update-IR in state 0 or 1, address 7'h3A (broadcast) moves `sel_state` to 3 (group selected).
- R6: At Update-IR in state 0 or 1, an address 7'h30+g with g in 0..3 moves `sel_state` to 3 only when the group register is valid and holds number g.
- R7: Any other address moves `sel_state` to 1 (unselected). `sel_state` changes only at Update-IR or Test-Logic-Reset, and an Update-IR while in state 1 runs the comparison again.
- R8: In states 2 and 3, Update-IR loads an instruction instead of an address, and the selection state is kept. Capture-IR loads 8'h01.
- R9: `tdo_oe` is high only during Shift-IR and Shift-DR in state 2. `tdo` changes on the falling edge of TCK and carries the low bit of the active shift path. In state 3 `tdo_oe` stays low.
- R10: Instruction 8'h03 selects the 3-bit group register. Bit 2 is the valid bit and bits 1:0 are the group number. The register is captured at Capture-DR and shifted in at its most significant end. It is written at Update-DR only in state 2; a write made in any other state is ignored.
- R11: Every instruction other than 8'h03 selects a 1-bit bypass stage that captures 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Scan clock |
| trst_n | input | 1 | Asynchronous active-low hardware reset |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial scan data in |
| slot_addr | input | 7 | Static slot address of this device |
| tdo | output | 1 | Serial scan data out, 0 while not enabled |
| tdo_oe | output | 1 | Output enable for the shared TDO pad |
| sel_state | output | 2 | 0 waiting, 1 unselected, 2 single, 3 group |

## Verification
On every cycle, the embedded properties check the following: the output enable is never high outside single selection, Test-Logic-Reset always leads back to waiting, the selection state moves only at Update-IR, instruction bits enter at the top, and the group register holds its value whenever the device is not singly selected. The scenarios are needed for the address decisions themselves. These cover the slot, broadcast and multicast hits, the invalid-group and wrong-number misses, readdressing out of the unselected state, and a group write attempted while group-selected that must not survive the later read-back. The scenarios also check the serial data seen on TDO.

// File: rtl/scan_sel_pkg.sv
package scan_sel_pkg;

  // TAP controller states
  typedef enum logic [3:0] {
    T_TLR    = 4'd0,
    T_RTI    = 4'd1,
    T_SEL_DR = 4'd2,
    T_CAP_DR = 4'd3,
    T_SH_DR  = 4'd4,
    T_EX1_DR = 4'd5,
    T_PAU_DR = 4'd6,
    T_EX2_DR = 4'd7,
    T_UPD_DR = 4'd8,
    T_SEL_IR = 4'd9,
    T_CAP_IR = 4'd10,
    T_SH_IR  = 4'd11,
    T_EX1_IR = 4'd12,
    T_PAU_IR = 4'd13,
    T_EX2_IR = 4'd14,
    T_UPD_IR = 4'd15
  } tap_st_e;

  // Device selection states (encoding visible on sel_state)
  typedef enum logic [1:0] {
    S_WAIT   = 2'd0,
    S_UNSEL  = 2'd1,
    S_SINGLE = 2'd2,
    S_GROUP  = 2'd3
  } sel_st_e;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import scan_sel_pkg::*;
(
  input  logic    tck,
  input  logic    trst_n,
  input  logic    tms,
  output tap_st_e st
);

  tap_st_e nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      T_TLR:    nxt = tms ? T_TLR    : T_RTI;
      T_RTI:    nxt = tms ? T_SEL_DR : T_RTI;
      T_SEL_DR: nxt = tms ? T_SEL_IR : T_CAP_DR;
      T_CAP_DR: nxt = tms ? T_EX1_DR : T_SH_DR;
      T_SH_DR:  nxt = tms ? T_EX1_DR : T_SH_DR;
      T_EX1_DR: nxt = tms ? T_UPD_DR : T_PAU_DR;
      T_PAU_DR: nxt = tms ? T_EX2_DR : T_PAU_DR;
      T_EX2_DR: nxt = tms ? T_UPD_DR : T_SH_DR;
      T_UPD_DR: nxt = tms ? T_SEL_DR : T_RTI;
      T_SEL_IR: nxt = tms ? T_TLR    : T_CAP_IR;
      T_CAP_IR: nxt = tms ? T_EX1_IR : T_SH_IR;
      T_SH_IR:  nxt = tms ? T_EX1_IR : T_SH_IR;
      T_EX1_IR: nxt = tms ? T_UPD_IR : T_PAU_IR;
      T_PAU_IR: nxt = tms ? T_EX2_IR : T_PAU_IR;
      T_EX2_IR: nxt = tms ? T_UPD_IR : T_SH_IR;
      T_UPD_IR: nxt = tms ? T_SEL_DR : T_RTI;
      default:  nxt = T_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) st <= T_TLR;
    else         st <= nxt;
  end

  // R2: five high TMS samples end in Test-Logic-Reset
  p_five_ones_tlr_r2: assert property (@(posedge tck) disable iff (!trst_n)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
      |=> (st == T_TLR));

endmodule

// File: rtl/ir_unit.sv
module ir_unit
  import scan_sel_pkg::*;
#(
  parameter int IR_W = 8,
  parameter logic [IR_W-1:0] CAP_VAL = 8'h01,
  parameter logic [IR_W-1:0] BYP_INS = 8'hFF
) (
  input  logic            tck,
  input  logic            trst_n,
  input  tap_st_e         st,
  input  logic            tdi,
  input  logic            inst_mode,
  output logic [IR_W-1:0] ir_sh,
  output logic [IR_W-1:0] ir_q
);

  // shift path: capture fixed pattern, shift in at the top
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh <= '0;
    end else if (st == T_CAP_IR) begin
      ir_sh <= CAP_VAL;
    end else if (st == T_SH_IR) begin
      ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end
  end

  // active instruction: only loaded once the device is selected
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_q <= BYP_INS;
    end else if (st == T_TLR) begin
      ir_q <= BYP_INS;
    end else if (st == T_UPD_IR && inst_mode) begin
      ir_q <= ir_sh;
    end
  end

  // R3: each Shift-IR edge places TDI at the most significant bit
  p_ir_msb_entry_r3: assert property (@(posedge tck) disable iff (!trst_n)
    (st == T_SH_IR) |=> (ir_sh[IR_W-1] == $past(tdi)));

  // R8: the instruction moves only on a selected Update-IR or a reset entry
  p_inst_hold_r8: assert property (@(posedge tck) disable iff (!trst_n)
    (st != T_TLR && !(st == T_UPD_IR && inst_mode)) |=> $stable(ir_q));

endmodule

// File: rtl/addr_match.sv
module addr_match #(
  parameter int ADDR_W = 7,
  parameter int GRP_BITS = 2,
  parameter logic [ADDR_W-1:0] BCAST_ADDR = 7'h3A,
  parameter logic [ADDR_W-1:0] MCAST_BASE = 7'h30
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [ADDR_W-1:0]   slot,
  input  logic                grp_valid,
  input  logic [GRP_BITS-1:0] grp_num,
  output logic                hit_single,
  output logic                hit_group
);

  localparam int HI_W = ADDR_W - GRP_BITS;

  logic [HI_W-1:0] base_hi;
  logic            in_mcast_window;
  logic            mcast_hit;
  logic            bcast_hit;

  assign base_hi         = MCAST_BASE[ADDR_W-1:GRP_BITS];
  assign in_mcast_window = (addr[ADDR_W-1:GRP_BITS] == base_hi);
  assign mcast_hit       = grp_valid && in_mcast_window &&
                           (addr[GRP_BITS-1:0] == grp_num);
  assign bcast_hit       = (addr == BCAST_ADDR);

  // slot match takes precedence over the shared addresses
  assign hit_single = (addr == slot);
  assign hit_group  = !hit_single && (bcast_hit || mcast_hit);

  // R6: a multicast decision is only possible with a valid group register
  always_comb begin
    if (hit_group && !bcast_hit) begin
      a_mcast_needs_valid_r6: assert (grp_valid);
    end
  end

endmodule

// File: rtl/sel_fsm.sv
module sel_fsm
  import scan_sel_pkg::*;
(
  input  logic    tck,
  input  logic    trst_n,
  input  tap_st_e st,
  input  logic    hit_single,
  input  logic    hit_group,
  output sel_st_e sel
);

  logic addressing;
  assign addressing = (sel == S_WAIT) || (sel == S_UNSEL);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sel <= S_WAIT;
    end else if (st == T_TLR) begin
      sel <= S_WAIT;
    end else if (st == T_UPD_IR && addressing) begin
      if (hit_single)     sel <= S_SINGLE;
      else if (hit_group) sel <= S_GROUP;
      else                sel <= S_UNSEL;
    end
  end

  // R2: reset state of the TAP always lands in waiting
  p_tlr_to_wait_r2: assert property (@(posedge tck) disable iff (!trst_n)
    (st == T_TLR) |=> (sel == S_WAIT));

  // R7: selection moves only at Update-IR or Test-Logic-Reset
  p_sel_moves_on_update_r7: assert property (@(posedge tck) disable iff (!trst_n)
    (st != T_UPD_IR && st != T_TLR) |=> $stable(sel));

  // R8: once selected, instruction updates keep the selection
  p_selected_sticky_r8: assert property (@(posedge tck) disable iff (!trst_n)
    ((sel == S_SINGLE || sel == S_GROUP) && st != T_TLR) |=> $stable(sel));

endmodule

// File: rtl/dr_unit.sv
module dr_unit
  import scan_sel_pkg::*;
#(
  parameter int GRP_BITS = 2
) (
  input  logic              tck,
  input  logic              trst_n,
  input  tap_st_e           st,
  input  sel_st_e           sel,
  input  logic              tdi,
  input  logic              grp_path,
  output logic [GRP_BITS:0] grp_q,
  output logic              dr_out
);

  localparam int GW = GRP_BITS + 1;

  logic [GW-1:0] grp_sh;
  logic          byp_q;
  logic          wr_ok;

  assign wr_ok = grp_path && (sel == S_SINGLE);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      grp_sh <= '0;
      byp_q  <= 1'b0;
    end else if (st == T_CAP_DR) begin
      if (grp_path) grp_sh <= grp_q;
      byp_q <= 1'b0;
    end else if (st == T_SH_DR) begin
      if (grp_path) grp_sh <= {tdi, grp_sh[GW-1:1]};
      byp_q <= tdi;
    end
  end

  // group register survives TAP reset; only the hardware reset clears it
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      grp_q <= '0;
    end else if (st == T_UPD_DR && wr_ok) begin
      grp_q <= grp_sh;
    end
  end

  assign dr_out = grp_path ? grp_sh[0] : byp_q;

  // R10: no write unless the device is singly selected
  p_grp_locked_r10: assert property (@(posedge tck) disable iff (!trst_n)
    (sel != S_SINGLE) |=> $stable(grp_q));

  // R11: bypass stage captures zero
  p_bypass_capture_r11: assert property (@(posedge tck) disable iff (!trst_n)
    (st == T_CAP_DR) |=> (byp_q == 1'b0));

endmodule

// File: rtl/scan_addr_select.sv
module scan_addr_select
  import scan_sel_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int IR_W = 8,
  parameter int GRP_BITS = 2,
  parameter logic [ADDR_W-1:0] BCAST_ADDR = 7'h3A,
  parameter logic [ADDR_W-1:0] MCAST_BASE = 7'h30,
  parameter logic [IR_W-1:0] GRP_INS = 8'h03,
  parameter logic [IR_W-1:0] CAP_VAL = 8'h01
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  input  logic [ADDR_W-1:0] slot_addr,
  output logic              tdo,
  output logic              tdo_oe,
  output logic [1:0]        sel_state
);

  localparam logic [IR_W-1:0] BYP_INS = {IR_W{1'b1}};

  tap_st_e           st;
  sel_st_e           sel;
  logic [IR_W-1:0]   ir_sh;
  logic [IR_W-1:0]   ir_q;
  logic [GRP_BITS:0] grp_q;
  logic              hit_single;
  logic              hit_group;
  logic              dr_out;
  logic              inst_mode;
  logic              grp_path;
  logic              tdo_q;
  logic              oe_q;

  assign inst_mode = (sel == S_SINGLE) || (sel == S_GROUP);
  assign grp_path  = (ir_q == GRP_INS);

  tap_fsm u_tap (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .st     (st)
  );

  ir_unit #(
    .IR_W    (IR_W),
    .CAP_VAL (CAP_VAL),
    .BYP_INS (BYP_INS)
  ) u_ir (
    .tck       (tck),
    .trst_n    (trst_n),
    .st        (st),
    .tdi       (tdi),
    .inst_mode (inst_mode),
    .ir_sh     (ir_sh),
    .ir_q      (ir_q)
  );

  addr_match #(
    .ADDR_W     (ADDR_W),
    .GRP_BITS   (GRP_BITS),
    .BCAST_ADDR (BCAST_ADDR),
    .MCAST_BASE (MCAST_BASE)
  ) u_match (
    .addr       (ir_sh[ADDR_W-1:0]),
    .slot       (slot_addr),
    .grp_valid  (grp_q[GRP_BITS]),
    .grp_num    (grp_q[GRP_BITS-1:0]),
    .hit_single (hit_single),
    .hit_group  (hit_group)
  );

  sel_fsm u_sel (
    .tck        (tck),
    .trst_n     (trst_n),
    .st         (st),
    .hit_single (hit_single),
    .hit_group  (hit_group),
    .sel        (sel)
  );

  dr_unit #(
    .GRP_BITS (GRP_BITS)
  ) u_dr (
    .tck      (tck),
    .trst_n   (trst_n),
    .st       (st),
    .sel      (sel),
    .tdi      (tdi),
    .grp_path (grp_path),
    .grp_q    (grp_q),
    .dr_out   (dr_out)
  );

  // output stage on the falling edge, driven only when singly selected
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q  <= (sel == S_SINGLE) && (st == T_SH_IR || st == T_SH_DR);
      tdo_q <= (st == T_SH_IR) ? ir_sh[0] : dr_out;
    end
  end

  assign tdo       = oe_q & tdo_q;
  assign tdo_oe    = oe_q;
  assign sel_state = sel;

  // R9: the pad is enabled only while singly selected
  p_oe_single_only_r9: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (sel == S_SINGLE));

  // R3: an unselected or waiting device never drives TDO
  p_quiet_before_select_r3: assert property (@(posedge tck) disable iff (!trst_n)
    (sel == S_WAIT || sel == S_UNSEL) |-> !tdo_oe);

endmodule

// File: tb/test_scan_addr_select.sv
module test_scan_addr_select;

  localparam int CLK_PERIOD = 20;
  localparam logic [6:0] SLOT = 7'h15;

  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic       tms = 1'b1;
  logic       tdi = 1'b0;
  logic [6:0] slot_addr = SLOT;
  logic       tdo;
  logic       tdo_oe;
  logic [1:0] sel_state;

  int tests = 0;
  int failed = 0;
  bit exp_q[$];

  always #(CLK_PERIOD / 2) tck = ~tck;

  scan_addr_select i_scan_addr_select (
    .tck       (tck),
    .trst_n    (trst_n),
    .tms       (tms),
    .tdi       (tdi),
    .slot_addr (slot_addr),
    .tdo       (tdo),
    .tdo_oe    (tdo_oe),
    .sel_state (sel_state)
  );

  task automatic chk(input int act, input int exp, input string req);
    tests++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    @(negedge tck);
    #1;
    tms = m;
    tdi = d;
    @(posedge tck);
    #1;
  endtask

  task automatic tap_reset();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  // driver: push expected TDO bits, then walk the IR path
  task automatic scan_ir(input logic [7:0] v, input bit expect_out);
    if (expect_out)
      for (int i = 0; i < 8; i++) exp_q.push_back((i == 0) ? 1'b1 : 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) step(i == 7, v[i]);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic scan_dr(input int n, input logic [7:0] v,
                         input bit expect_out, input logic [7:0] e);
    if (expect_out)
      for (int i = 0; i < n; i++) exp_q.push_back(e[i]);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    for (int i = 0; i < n; i++) step(i == n - 1, v[i]);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  // monitor: every enabled TDO bit is compared with the scoreboard (R9)
  always begin
    @(posedge tck);
    #2;
    if (trst_n && tdo_oe) begin
      tests++;
      if (exp_q.size() == 0) begin
        failed++;
        $display("FAIL R9 unexpected enabled tdo actual=%0d expected=released", tdo);
      end else begin
        bit e;
        e = exp_q.pop_front();
        if (tdo != e) begin
          failed++;
          $display("FAIL R9 tdo bit actual=%0d expected=%0d", tdo, e);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    tests++;
    failed++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge tck);
    #1;
    chk(sel_state, 0, "R1 sel during reset");
    chk(tdo_oe, 0, "R1 oe during reset");
    @(negedge tck);
    trst_n = 1'b1;
    step(1'b0, 1'b0);

    // R7: miss goes unselected, R3 no output meanwhile
    scan_ir(8'h2A, 1'b0);
    chk(sel_state, 1, "R7 mismatch to unselected");
    chk(tdo_oe, 0, "R3 oe low while unselected");

    // R7 readdress from unselected, R4 slot hit
    scan_ir({1'b0, SLOT}, 1'b0);
    chk(sel_state, 2, "R4 slot hit single");

    // R8 capture pattern out, load group instruction
    scan_ir(8'h03, 1'b1);
    chk(sel_state, 2, "R8 instruction keeps single");
    // R10 read cleared register while writing valid group 2
    scan_dr(3, 8'h06, 1'b1, 8'h00);
    scan_dr(3, 8'h06, 1'b1, 8'h06);

    // R11 bypass: one stage delay starting at zero
    scan_ir(8'hFF, 1'b1);
    scan_dr(4, 8'b1101, 1'b1, 8'b1010);
    chk(exp_q.size(), 0, "R11 bypass bits consumed");

    // R2 TAP reset returns to waiting
    tap_reset();
    chk(sel_state, 0, "R2 TLR to waiting");

    // R6 multicast hit on group 2
    scan_ir(8'h32, 1'b0);
    chk(sel_state, 3, "R6 multicast group hit");
    // R9 no output in group state, R10 write attempt ignored
    scan_ir(8'h03, 1'b0);
    scan_dr(3, 8'h01, 1'b0, 8'h00);
    chk(sel_state, 3, "R8 group state kept");
    chk(tdo_oe, 0, "R9 oe low in group state");

    // R6 wrong number misses
    tap_reset();
    scan_ir(8'h31, 1'b0);
    chk(sel_state, 1, "R6 wrong group number");

    // R5 broadcast
    tap_reset();
    scan_ir(8'h3A, 1'b0);
    chk(sel_state, 3, "R5 broadcast hit");

    // R10 value survived the ignored write; then clear the valid bit
    tap_reset();
    scan_ir({1'b0, SLOT}, 1'b0);
    chk(sel_state, 2, "R4 reselect single");
    scan_ir(8'h03, 1'b1);
    scan_dr(3, 8'h02, 1'b1, 8'h06);

    // R6 invalid group register blocks multicast
    tap_reset();
    scan_ir(8'h32, 1'b0);
    chk(sel_state, 1, "R6 invalid group no hit");

    // R4 bit 7 ignored in address
    tap_reset();
    scan_ir({1'b1, SLOT}, 1'b0);
    chk(sel_state, 2, "R4 high bit ignored");

    // R1 hardware reset clears group register
    @(negedge tck);
    trst_n = 1'b0;
    #1;
    chk(sel_state, 0, "R1 async reset state");
    chk(tdo_oe, 0, "R1 async reset oe");
    @(negedge tck);
    trst_n = 1'b1;
    step(1'b0, 1'b0);
    scan_ir({1'b0, SLOT}, 1'b0);
    scan_ir(8'h03, 1'b1);
    scan_dr(3, 8'h00, 1'b1, 8'h00);

    step(1'b0, 1'b0);
    chk(exp_q.size(), 0, "R9 all expected bits seen");
    finish_run();
  end

endmodule